// File: doc/BRIEF.md
# Double-precision round-and-pack stage

This block is the last combinational step of a binary floating-point datapath. It takes a result that an earlier stage has already normalized, held as a sign, a biased exponent with spare range on both sides, a significand with its hidden bit, and three extra low bits. It produces the final packed encoding and the overflow, underflow and inexact exception flags. A 2-bit mode input chooses one of four rounding directions for each operation.

The input value is (-1)^sign × {mant_i, grs_i} × 2^(exp_i − BIAS − FRAC_W − 3), where BIAS = 2^(EXP_W−1) − 1. In this form mant_i reads as 1.f and the hidden bit is mant_i[FRAC_W]. exp_i is a signed two's-complement field with more bits than the output exponent, so the block can see values far above the largest finite number and far below the smallest normal one.

When the exponent is below 1, the block denormalizes the value and rounds it as a subnormal. When the rounded value does not fit, it saturates to infinity or to the largest finite value, depending on the mode and the sign. NaN handling and normalization happen outside this block. The default parameters give IEEE binary64. Any smaller format with the same layout can be built from the same parameters.

Top module: `fp_round_pack`

## Requirements
- R1: rmode_i selects the direction: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward −infinity. Under nearest-even an exact half-ulp tie goes to the encoding whose fraction LSB is 0.
- R2: Toward zero never increases the magnitude. Discarded bits are dropped.
- R3: A discarded nonzero remainder increments the magnitude under toward +infinity for positive results and under toward −infinity for negative results. It truncates under the opposite directed mode.
- R4: A rounding carry out of the significand adds one to the exponent and clears the fraction. If the new exponent reaches all ones, the result overflows.
- R5: On overflow, nearest-even and the mode pointing away from zero for the result's sign give infinity (exponent all ones, fraction 0). The other two modes give the largest finite value (exponent all ones minus 1, fraction all ones). The sign is kept.
- R6: Every overflow raises ovf_o and inx_o together.
- R7: For exp_i below 1, the significand shifts right by 1 − exp_i before rounding, to give a subnormal (exponent field 0). Every bit shifted out counts toward the sticky remainder.
- R8: A nonzero value far below the smallest subnormal becomes a signed zero, or the smallest subnormal (magnitude encoding 1) when the mode points away from zero for its sign.
- R9: unf_o is raised only when exp_i is below 1 and the result is inexact. An exactly representable subnormal raises no flag.
- R10: inx_o is raised exactly when the returned value differs from the input value.
- R11: An all-zero mant_i and grs_i gives a zero of the input sign with no flags, under every mode.
- R12: result_o holds the sign in its MSB, then EXP_W exponent bits, then FRAC_W fraction bits. grs_i carries guard in bit 2, round in bit 1 and sticky in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rmode_i | input | 2 | Rounding direction code |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXT_W | Signed biased exponent with headroom |
| mant_i | input | FRAC_W+1 | Significand, hidden bit in MSB |
| grs_i | input | 3 | Guard, round and sticky bits |
| result_o | output | EXP_W+FRAC_W+1 | Packed rounded result |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag (tiny and inexact) |
| inx_o | output | 1 | Inexact flag |

## Verification
The block holds no state, so a wrong internal value shows at the ports as soon as the inputs settle, in the same evaluation. A lost sticky bit appears as a wrong fraction LSB under a directed mode, or as a missing inexact or underflow flag. A wrong denormalization shift appears as a subnormal that is off by a power of two. A wrong carry or saturation choice appears in the exponent field or as a wrong ovf_o. A reduced format is swept over every normalized significand, every extra-bit pattern, both signs, all modes and an exponent range that covers flush to zero through overflow. Each result is compared with a scan over all finite encodings. Binary64 is checked at the overflow, tiny, tie and carry corners.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } rmode_e;

   // true when the mode moves the magnitude away from zero for this sign
   function automatic logic away_from_zero(input logic [1:0] rm, input logic sgn);
      return (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);
   endfunction

endpackage

// File: rtl/fpr_align.sv
module fpr_align #(
   parameter int FRAC_W = 52,
   parameter int EXT_W  = 14
) (
   input  logic signed [EXT_W-1:0] exp_i,
   input  logic [FRAC_W:0]         mant_i,
   input  logic [2:0]              grs_i,
   output logic [FRAC_W:0]         keep_o,
   output logic                    rbit_o,
   output logic                    sticky_o,
   output logic                    tiny_o
);
   localparam int W    = FRAC_W + 4;
   localparam int SH_W = $clog2(W + 1);

   logic signed [EXT_W:0] sh_wide;
   logic [SH_W-1:0]       sh_c;
   logic [W-1:0]          lvl [SH_W+1];
   logic                  stk [SH_W+1];

   assign tiny_o  = exp_i < $signed(EXT_W'(1));
   assign sh_wide = (EXT_W+1)'(1) - (EXT_W+1)'(exp_i);

   always_comb begin
      if (!tiny_o)
         sh_c = '0;
      else if (sh_wide > W)
         sh_c = SH_W'(W);
      else
         sh_c = sh_wide[SH_W-1:0];
   end

   assign lvl[0] = {mant_i, grs_i};
   assign stk[0] = 1'b0;

   // logarithmic right shifter; each stage folds its dropped bits into sticky
   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int AMT = 1 << k;
      localparam logic [W-1:0] MASK = (AMT >= W) ? {W{1'b1}} : ~({W{1'b1}} << AMT);
      assign lvl[k+1] = sh_c[k] ? (lvl[k] >> AMT) : lvl[k];
      assign stk[k+1] = stk[k] | (sh_c[k] & (|(lvl[k] & MASK)));
   end

   assign keep_o   = lvl[SH_W][W-1:3];
   assign rbit_o   = lvl[SH_W][2];
   assign sticky_o = (|lvl[SH_W][1:0]) | stk[SH_W];

   always_comb begin
      if (!tiny_o) begin
         assert_pass_through_R7: assert (keep_o == mant_i && rbit_o == grs_i[2]
                                          && sticky_o == (|grs_i[1:0]))
            else $error("normal exponent altered the significand");
      end
   end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr
   import fpr_pkg::*;
#(
   parameter int FRAC_W = 52
) (
   input  logic [1:0]        rmode_i,
   input  logic              sign_i,
   input  logic [FRAC_W:0]   keep_i,
   input  logic              rbit_i,
   input  logic              sticky_i,
   output logic [FRAC_W+1:0] sum_o,
   output logic              inexact_o
);
   logic inc;

   assign inexact_o = rbit_i | sticky_i;

   always_comb begin
      unique case (rmode_e'(rmode_i))
         RM_NEAR: inc = rbit_i & (sticky_i | keep_i[0]);
         RM_ZERO: inc = 1'b0;
         RM_UP:   inc = !sign_i & inexact_o;
         RM_DOWN: inc = sign_i & inexact_o;
         default: inc = 1'b0;
      endcase
   end

   assign sum_o = {1'b0, keep_i} + (FRAC_W+2)'(inc);

   always_comb begin
      if (rmode_i == RM_ZERO) begin
         assert_truncate_R2: assert (sum_o[FRAC_W:0] == keep_i && !sum_o[FRAC_W+1])
            else $error("toward-zero grew the magnitude");
      end
      if (!inexact_o) begin
         assert_exact_kept_R10: assert (sum_o == {1'b0, keep_i})
            else $error("exact value was changed");
      end
   end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
   import fpr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int EXT_W  = 14
) (
   input  logic [1:0]              rmode_i,
   input  logic                    sign_i,
   input  logic signed [EXT_W-1:0] exp_i,
   input  logic                    tiny_i,
   input  logic                    zero_i,
   input  logic [FRAC_W+1:0]       sum_i,
   input  logic                    inexact_i,
   output logic [EXP_W+FRAC_W:0]   result_o,
   output logic                    ovf_o,
   output logic                    unf_o,
   output logic                    inx_o
);
   localparam int EMAX  = (1 << EXP_W) - 1;
   localparam int MAG_W = EXP_W + FRAC_W;
   localparam logic [MAG_W-1:0] MAG_INF = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   localparam logic [MAG_W-1:0] MAG_MAX = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

   logic                  carry;
   logic signed [EXT_W:0] exp_after;
   logic                  to_inf;
   logic [MAG_W-1:0]      mag_norm, mag_tiny, mag;

   assign carry     = sum_i[FRAC_W+1];
   assign exp_after = (EXT_W+1)'(exp_i) + (EXT_W+1)'(carry);
   assign ovf_o     = !zero_i && !tiny_i && (exp_after >= $signed((EXT_W+1)'(EMAX)));
   assign to_inf    = (rmode_i == RM_NEAR) || away_from_zero(rmode_i, sign_i);

   assign mag_norm  = {exp_after[EXP_W-1:0], sum_i[FRAC_W-1:0]};
   assign mag_tiny  = {{(EXP_W-1){1'b0}}, sum_i[FRAC_W:0]};

   always_comb begin
      if (zero_i)      mag = '0;
      else if (ovf_o)  mag = to_inf ? MAG_INF : MAG_MAX;
      else if (tiny_i) mag = mag_tiny;
      else             mag = mag_norm;
   end

   assign result_o = {sign_i, mag};
   assign inx_o    = !zero_i && (ovf_o || inexact_i);
   assign unf_o    = !zero_i && tiny_i && inexact_i;

   always_comb begin
      if (carry && !zero_i) begin
         assert_carry_clears_R4: assert (sum_i[FRAC_W-1:0] == '0)
            else $error("carry left fraction bits set");
      end
      if (ovf_o) begin
         assert_sat_value_R5: assert (result_o[MAG_W-1:0] == MAG_INF
                                      || result_o[MAG_W-1:0] == MAG_MAX)
            else $error("overflow result is neither infinity nor max");
         assert_no_overflow_inx_R6: assert (inx_o)
            else $error("overflow without inexact");
      end
      if (unf_o) begin
         assert_unf_tiny_R9: assert (tiny_i && inx_o)
            else $error("underflow on a non-tiny or exact result");
      end
   end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int EXT_W  = 14
) (
   input  logic [1:0]              rmode_i,
   input  logic                    sign_i,
   input  logic signed [EXT_W-1:0] exp_i,
   input  logic [FRAC_W:0]         mant_i,
   input  logic [2:0]              grs_i,
   output logic [EXP_W+FRAC_W:0]   result_o,
   output logic                    ovf_o,
   output logic                    unf_o,
   output logic                    inx_o
);
   localparam int MAG_W = EXP_W + FRAC_W;

   if (EXP_W < 3) begin : g_bad_exp
      $error("EXP_W must be at least 3");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("FRAC_W must be at least 2");
   end
   if (EXT_W < EXP_W + 2) begin : g_bad_ext
      $error("EXT_W needs two bits of headroom over EXP_W");
   end

   logic                zero;
   logic [FRAC_W:0]     keep;
   logic                rbit, sticky, tiny, inexact;
   logic [FRAC_W+1:0]   sum;

   assign zero = (mant_i == '0) && (grs_i == '0);

   fpr_align #(.FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_align (
      .exp_i   (exp_i),
      .mant_i  (mant_i),
      .grs_i   (grs_i),
      .keep_o  (keep),
      .rbit_o  (rbit),
      .sticky_o(sticky),
      .tiny_o  (tiny)
   );

   fpr_incr #(.FRAC_W(FRAC_W)) u_incr (
      .rmode_i  (rmode_i),
      .sign_i   (sign_i),
      .keep_i   (keep),
      .rbit_i   (rbit),
      .sticky_i (sticky),
      .sum_o    (sum),
      .inexact_o(inexact)
   );

   fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_pack (
      .rmode_i  (rmode_i),
      .sign_i   (sign_i),
      .exp_i    (exp_i),
      .tiny_i   (tiny),
      .zero_i   (zero),
      .sum_i    (sum),
      .inexact_i(inexact),
      .result_o (result_o),
      .ovf_o    (ovf_o),
      .unf_o    (unf_o),
      .inx_o    (inx_o)
   );

   always_comb begin
      if (zero) begin
         assert_zero_clean_R11: assert (result_o[MAG_W-1:0] == '0 && !ovf_o && !unf_o && !inx_o)
            else $error("zero input gave nonzero result or flags");
      end
      assert_no_nan_R12: assert (!(result_o[MAG_W-1:FRAC_W] == '1 && result_o[FRAC_W-1:0] != '0))
         else $error("NaN pattern produced");
   end
endmodule

// File: tb/sim_fp_round_pack.sv
module sim_fp_round_pack;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // binary64 instance
   logic [1:0]         a_rm;
   logic               a_s;
   logic signed [13:0] a_e;
   logic [52:0]        a_m;
   logic [2:0]         a_g;
   logic [63:0]        a_res;
   logic               a_ovf, a_unf, a_inx;

   fp_round_pack u0 (
      .rmode_i(a_rm), .sign_i(a_s), .exp_i(a_e), .mant_i(a_m), .grs_i(a_g),
      .result_o(a_res), .ovf_o(a_ovf), .unf_o(a_unf), .inx_o(a_inx)
   );

   // reduced format: 4 exponent bits, 3 fraction bits
   logic [1:0]        b_rm;
   logic              b_s;
   logic signed [6:0] b_e;
   logic [3:0]        b_m;
   logic [2:0]        b_g;
   logic [7:0]        b_res;
   logic              b_ovf, b_unf, b_inx;

   fp_round_pack #(.EXP_W(4), .FRAC_W(3), .EXT_W(7)) u1 (
      .rmode_i(b_rm), .sign_i(b_s), .exp_i(b_e), .mant_i(b_m), .grs_i(b_g),
      .result_o(b_res), .ovf_o(b_ovf), .unf_o(b_unf), .inx_o(b_inx)
   );

   // value of positive reduced encoding n, in units of 2^-50
   function automatic longint enc_val(input int n);
      int e = n >> 3;
      int f = n & 7;
      if (e == 0) return longint'(f) << 41;
      return longint'(8 + f) << (e - 1 + 41);
   endfunction

   // returns {encoding, ovf, unf, inx}
   function automatic logic [10:0] ref_small(input logic s, input logic [1:0] rm,
                                             input int e, input int m7);
      longint v, maxv, ulp, lov, hiv, d1, d2;
      int lo, idx;
      logic away, ovf, inx, tiny;
      if (m7 == 0) return {s, 7'd0, 3'b000};
      v    = longint'(m7) << (e + 37);
      maxv = enc_val(119);
      ulp  = longint'(1) << 54;
      away = (rm == 2'd2 && !s) || (rm == 2'd3 && s);
      if (rm == 2'd0)  ovf = v >= maxv + ulp / 2;
      else if (away)   ovf = v > maxv;
      else             ovf = v >= maxv + ulp;
      if (ovf) begin
         idx = (rm == 2'd0 || away) ? 120 : 119;
         return {s, 7'(idx), 3'b101};
      end
      lo = 0;
      for (int n = 0; n <= 120; n++) if (enc_val(n) <= v) lo = n;
      lov = enc_val(lo);
      hiv = enc_val(lo + 1);
      inx = (v != lov);
      if (!inx)             idx = lo;
      else if (rm == 2'd1)  idx = lo;
      else if (away)        idx = lo + 1;
      else if (rm == 2'd0) begin
         d1 = v - lov;
         d2 = hiv - v;
         if (d1 < d2)      idx = lo;
         else if (d2 < d1) idx = lo + 1;
         else              idx = (lo % 2 == 0) ? lo : lo + 1;
      end
      else idx = lo;
      tiny = v < enc_val(8);
      return {s, 7'(idx), 1'b0, tiny & inx, inx};
   endfunction

   task automatic run_small(input logic s, input logic [1:0] rm, input int e, input int m7);
      logic [10:0] want;
      string tag;
      @(posedge clk);
      b_s  = s;
      b_rm = rm;
      b_e  = 7'(e);
      b_m  = 4'(m7 >> 3);
      b_g  = 3'(m7);
      @(negedge clk);
      want = ref_small(s, rm, e, m7);
      if (m7 == 0)            tag = "R11";
      else if (want[2])       tag = "R5";
      else if (e < -3)        tag = "R8";
      else if (e < 1)         tag = "R7";
      else if (rm == 2'd0)    tag = "R1";
      else if (rm == 2'd1)    tag = "R2";
      else                    tag = "R3";
      total++;
      if ({b_res, b_ovf, b_unf, b_inx} !== want) begin
         bad++;
         $display("FAIL %s s=%0d rm=%0d e=%0d m=%0d got=%h/%b want=%h/%b", tag, s, rm, e,
                  m7, b_res, {b_ovf, b_unf, b_inx}, want[10:3], want[2:0]);
      end
   endtask

   task automatic run64(input string tag, input logic s, input logic [1:0] rm,
                        input int e, input logic [52:0] m, input logic [2:0] g,
                        input logic [63:0] want, input logic [2:0] wfl);
      @(posedge clk);
      a_s  = s;
      a_rm = rm;
      a_e  = 14'(e);
      a_m  = m;
      a_g  = g;
      @(negedge clk);
      total++;
      if (a_res !== want || {a_ovf, a_unf, a_inx} !== wfl) begin
         bad++;
         $display("FAIL %s rm=%0d got=%h/%b want=%h/%b", tag, rm, a_res,
                  {a_ovf, a_unf, a_inx}, want, wfl);
      end
   endtask

   localparam logic [52:0] ONE  = 53'h10_0000_0000_0000;
   localparam logic [52:0] ALL1 = 53'h1F_FFFF_FFFF_FFFF;
   localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] PMAX = 64'h7FEF_FFFF_FFFF_FFFF;
   localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] NMAX = 64'hFFEF_FFFF_FFFF_FFFF;

   initial begin
      a_rm = 0; a_s = 0; a_e = 0; a_m = 0; a_g = 0;
      b_rm = 0; b_s = 0; b_e = 0; b_m = 0; b_g = 0;

      // zero inputs, all modes and signs (R11)
      for (int rm = 0; rm < 4; rm++) begin
         run64("R11", 1'b0, 2'(rm), 5, 53'd0, 3'd0, 64'd0, 3'b000);
         run64("R11", 1'b1, 2'(rm), 5, 53'd0, 3'd0, 64'h8000_0000_0000_0000, 3'b000);
      end

      // overflow of twice the largest finite (R5, R6)
      run64("R5", 1'b0, 2'd0, 2047, ALL1, 3'd0, PINF, 3'b101);
      run64("R5", 1'b0, 2'd1, 2047, ALL1, 3'd0, PMAX, 3'b101);
      run64("R5", 1'b0, 2'd2, 2047, ALL1, 3'd0, PINF, 3'b101);
      run64("R5", 1'b0, 2'd3, 2047, ALL1, 3'd0, PMAX, 3'b101);
      run64("R6", 1'b1, 2'd0, 2047, ALL1, 3'd0, NINF, 3'b101);
      run64("R6", 1'b1, 2'd1, 2047, ALL1, 3'd0, NMAX, 3'b101);
      run64("R6", 1'b1, 2'd2, 2047, ALL1, 3'd0, NMAX, 3'b101);
      run64("R6", 1'b1, 2'd3, 2047, ALL1, 3'd0, NINF, 3'b101);

      // far-below results (R8, R9)
      run64("R8", 1'b0, 2'd0, -1000, ONE, 3'd0, 64'd0, 3'b011);
      run64("R8", 1'b0, 2'd1, -1000, ONE, 3'd0, 64'd0, 3'b011);
      run64("R8", 1'b0, 2'd2, -1000, ONE, 3'd0, 64'd1, 3'b011);
      run64("R8", 1'b0, 2'd3, -1000, ONE, 3'd0, 64'd0, 3'b011);
      run64("R8", 1'b1, 2'd3, -1000, ONE, 3'd0, 64'h8000_0000_0000_0001, 3'b011);
      run64("R8", 1'b1, 2'd2, -1000, ONE, 3'd0, 64'h8000_0000_0000_0000, 3'b011);

      // exactly representable smallest subnormal: no flags (R9, R7)
      for (int rm = 0; rm < 4; rm++)
         run64("R9", 1'b0, 2'(rm), -51, ONE, 3'd0, 64'd1, 3'b000);

      // just above 1 + 2 ulp (R3, R10)
      run64("R10", 1'b0, 2'd0, 1023, 53'h10_0000_0000_0002, 3'b001, 64'h3FF0_0000_0000_0002, 3'b001);
      run64("R2",  1'b0, 2'd1, 1023, 53'h10_0000_0000_0002, 3'b001, 64'h3FF0_0000_0000_0002, 3'b001);
      run64("R3",  1'b0, 2'd2, 1023, 53'h10_0000_0000_0002, 3'b001, 64'h3FF0_0000_0000_0003, 3'b001);
      run64("R3",  1'b0, 2'd3, 1023, 53'h10_0000_0000_0002, 3'b001, 64'h3FF0_0000_0000_0002, 3'b001);
      run64("R3",  1'b1, 2'd3, 1023, 53'h10_0000_0000_0002, 3'b001, 64'hBFF0_0000_0000_0003, 3'b001);

      // nearest-even ties (R1)
      run64("R1", 1'b0, 2'd0, 1023, 53'h10_0000_0000_0001, 3'b100, 64'h3FF0_0000_0000_0002, 3'b001);
      run64("R1", 1'b0, 2'd0, 1023, 53'h10_0000_0000_0002, 3'b100, 64'h3FF0_0000_0000_0002, 3'b001);

      // carry out of the significand (R4)
      run64("R4", 1'b0, 2'd0, 1023, ALL1, 3'b110, 64'h4000_0000_0000_0000, 3'b001);
      run64("R4", 1'b0, 2'd0, 2046, ALL1, 3'b100, PINF, 3'b101);
      run64("R4", 1'b0, 2'd1, 2046, ALL1, 3'b100, PMAX, 3'b001);
      run64("R4", 1'b0, 2'd0, 0, ALL1, 3'b000, 64'h0010_0000_0000_0000, 3'b011);

      // field layout (R12): -1.5 exact
      run64("R12", 1'b1, 2'd0, 1023, 53'h18_0000_0000_0000, 3'd0, 64'hBFF8_0000_0000_0000, 3'b000);

      // exhaustive sweep of the reduced format
      for (int s = 0; s < 2; s++)
         for (int rm = 0; rm < 4; rm++) begin
            run_small(1'(s), 2'(rm), 3, 0);
            for (int e = -30; e <= 17; e++)
               for (int m7 = 64; m7 < 128; m7++)
                  run_small(1'(s), 2'(rm), e, m7);
         end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule